// File: doc/BRIEF.md
# Panel SPI Command Framer

This block turns a stream of command and data bytes into framed, write-only SPI traffic for an e-paper panel controller. It also drives the panel's hardware reset line. Upstream logic offers one byte at a time on a valid/ready handshake. Each byte carries two flags: whether it is a command or data, and whether it ends a data burst. On the panel side the block drives a serial clock, a serial data line, an active-low chip select, a command/data select and an active-low reset.

Command bytes always travel in a frame of their own. A data byte whose last flag is clear keeps chip select low, so that the following data bytes join the same frame. A bulk image transfer therefore costs one chip-select cycle, not one per byte. Between frames chip select stays high for a minimum gap.

A reset request starts a three-phase sequence on the reset line: high, then low, then high again. A one-cycle done pulse follows it. The phase lengths are given in milliseconds and converted using the system clock frequency parameter. The serial clock rate comes from a divider parameter that sets the half-period in system clocks.

Top module: `epd_spi_framer`

## Requirements
- R1: After the system reset, the outputs are `panel_cs_n`=1, `panel_dc`=1, `panel_sclk`=0, `panel_rst_n`=1 and `in_ready`=1.
- R2: Each byte is sent most significant bit first in SPI mode 0. `panel_sclk` idles low. `panel_mosi` changes only while `panel_sclk` is low, and each bit is valid at the rising edge of `panel_sclk`.
- R3: Every high phase and every low phase of `panel_sclk` inside a byte lasts exactly SCK_DIV system clocks.
- R4: `panel_dc` is 0 for a command byte and 1 for a data byte. It takes its value before `panel_cs_n` falls and does not change while `panel_cs_n` is low. After a command, `panel_cs_n` rises first and `panel_dc` returns to 1 afterwards.
- R5: A data byte with `in_last`=1 that does not follow an open burst is sent in a frame of its own, and `panel_cs_n` rises after it.
- R6: A data byte with `in_last`=0 keeps `panel_cs_n` low after it. The next data byte joins the same frame, and the frame closes after the first following byte that has `in_last`=1.
- R7: A command byte that arrives while a burst is open first closes the burst (`panel_cs_n` high), then goes out in a new frame. The `in_last` flag of a command has no effect.
- R8: A one-cycle `rst_req` pulse holds `panel_rst_n` high for at least RST_PRE_MS ms. It then drives `panel_rst_n` low for exactly RST_LOW_MS ms and high for exactly RST_POST_MS ms, and then pulses `rst_done` for one cycle. One ms is CLK_HZ/1000 system clocks.
- R9: A reset request that arrives during a byte waits until the byte is complete and `panel_cs_n` is high. It closes any open burst, and `panel_rst_n` is never low while `panel_cs_n` is low.
- R10: `in_ready` is 0 while `panel_sclk` is high or a byte is shifting, while chip select is being released, and for the whole reset sequence.
- R11: Between two frames, `panel_cs_n` stays high for at least SCK_DIV system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| in_valid | input | 1 | Upstream byte valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| in_byte | input | 8 | Byte to send |
| in_is_cmd | input | 1 | 1 = command byte, 0 = data byte |
| in_last | input | 1 | 1 = data byte ends its burst |
| rst_req | input | 1 | Request the panel reset sequence (one-cycle pulse) |
| rst_done | output | 1 | One-cycle pulse when the reset sequence ends |
| panel_sclk | output | 1 | SPI serial clock, idles low |
| panel_mosi | output | 1 | SPI serial data, MSB first |
| panel_cs_n | output | 1 | Active-low chip select |
| panel_dc | output | 1 | 0 = command, 1 = data |
| panel_rst_n | output | 1 | Active-low panel reset line |

## Verification
The bench builds the block with CLK_HZ=4000 and SCK_DIV=3. With these values one millisecond is four clocks, so the whole three-phase reset takes about 170 cycles and its exact low and trailing durations can be counted. The odd divider checks that each clock phase is counted in whole system clocks and not derived from a power of two. Short frames also let the bench cover, in a few hundred cycles, a reset that is deferred in the middle of a byte, a burst that a command interrupts, and back-to-back command frames.

// File: rtl/epd_spi_pkg.sv
`timescale 1ns/1ps
package epd_spi_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_SETUP,
        FS_SHIFT,
        FS_LINK,
        FS_TAIL,
        FS_GAP,
        FS_RESET
    } fr_state_e;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_PRE,
        RP_LOW,
        RP_POST
    } rp_phase_e;

endpackage

// File: rtl/epd_sck_div.sv
`timescale 1ns/1ps
module epd_sck_div #(
    parameter int SCK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(SCK_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R3: with a divider above one, two ticks are never adjacent
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (SCK_DIV > 1)) |=> !tick);

endmodule

// File: rtl/epd_rst_seq.sv
`timescale 1ns/1ps
module epd_rst_seq
    import epd_spi_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int RST_PRE_MS  = 20,
    parameter int RST_LOW_MS  = 2,
    parameter int RST_POST_MS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic line_n,
    output logic done
);
    localparam int MS_CYC   = (CLK_HZ >= 1000) ? CLK_HZ / 1000 : 1;
    localparam int PRE_CYC  = (MS_CYC * RST_PRE_MS  > 0) ? MS_CYC * RST_PRE_MS  : 1;
    localparam int LOW_CYC  = (MS_CYC * RST_LOW_MS  > 0) ? MS_CYC * RST_LOW_MS  : 1;
    localparam int POST_CYC = (MS_CYC * RST_POST_MS > 0) ? MS_CYC * RST_POST_MS : 1;
    localparam int MAX_CYC  = (PRE_CYC > POST_CYC) ?
                              ((PRE_CYC > LOW_CYC) ? PRE_CYC : LOW_CYC) :
                              ((POST_CYC > LOW_CYC) ? POST_CYC : LOW_CYC);
    localparam int CW       = $clog2(MAX_CYC + 1);

    typedef struct packed {
        rp_phase_e     phase;
        logic [CW-1:0] cnt;
        logic          done;
    } rs_regs_t;

    localparam rs_regs_t RS_RST = '{phase: RP_IDLE, cnt: '0, done: 1'b0};

    rs_regs_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.phase)
            RP_IDLE: begin
                if (start) begin
                    d.phase = RP_PRE;
                    d.cnt   = '0;
                end
            end
            RP_PRE: begin
                if (q.cnt == CW'(PRE_CYC - 1)) begin
                    d.phase = RP_LOW;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RP_LOW: begin
                if (q.cnt == CW'(LOW_CYC - 1)) begin
                    d.phase = RP_POST;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RP_POST: begin
                if (q.cnt == CW'(POST_CYC - 1)) begin
                    d.phase = RP_IDLE;
                    d.cnt   = '0;
                    d.done  = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d = RS_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RS_RST;
        else        q <= d;
    end

    assign line_n = (q.phase != RP_LOW);
    assign done   = q.done;

    // R8: done only ever follows the trailing high phase
    a_r8_done_after_post: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> ($past(q.phase) == RP_POST));

    // R8: the low phase is always entered from the leading high phase
    a_r8_low_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_n) |-> ($past(q.phase) == RP_PRE));

endmodule

// File: rtl/epd_spi_frame.sv
`timescale 1ns/1ps
module epd_spi_frame
    import epd_spi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_cmd,
    input  logic       in_last,
    input  logic       rst_req,
    input  logic       tick,
    output logic       div_en,
    output logic       seq_start,
    input  logic       seq_done,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       dc
);
    typedef struct packed {
        fr_state_e  st;
        logic [7:0] sh;
        logic [3:0] half;
        logic       is_cmd;
        logic       last;
        logic       held;
        logic       pend;
        logic       sclk;
        logic       cs_n;
        logic       dc;
    } fr_regs_t;

    localparam fr_regs_t FR_RST = '{
        st: FS_IDLE, sh: 8'h00, half: 4'h0, is_cmd: 1'b0, last: 1'b0,
        held: 1'b0, pend: 1'b0, sclk: 1'b0, cs_n: 1'b1, dc: 1'b1
    };

    fr_regs_t d, q;
    logic     accept;

    always_comb begin
        in_ready  = ((q.st == FS_IDLE) || (q.st == FS_LINK)) && !q.pend;
        accept    = in_valid && in_ready;
        div_en    = (q.st == FS_SETUP) || (q.st == FS_SHIFT) ||
                    (q.st == FS_TAIL)  || (q.st == FS_GAP);
        seq_start = (q.st == FS_IDLE) && q.pend;

        d      = q;
        d.pend = q.pend | rst_req;

        case (q.st)
            FS_IDLE: begin
                if (q.pend) begin
                    d.st   = FS_RESET;
                    d.pend = rst_req;
                end else if (accept) begin
                    d.sh     = in_byte;
                    d.is_cmd = in_is_cmd;
                    d.last   = in_last;
                    d.dc     = !in_is_cmd;
                    d.st     = FS_SETUP;
                end
            end
            FS_SETUP: begin
                if (tick) begin
                    d.cs_n = 1'b0;
                    d.half = 4'h0;
                    d.st   = FS_SHIFT;
                end
            end
            FS_SHIFT: begin
                if (tick) begin
                    d.half = q.half + 4'h1;
                    if (!q.half[0]) begin
                        d.sclk = 1'b1;
                    end else begin
                        d.sclk = 1'b0;
                        d.sh   = {q.sh[6:0], 1'b0};
                    end
                    if (q.half == 4'hF) begin
                        if (q.is_cmd || q.last) begin
                            d.cs_n = 1'b1;
                            d.held = 1'b0;
                            d.st   = FS_TAIL;
                        end else begin
                            d.st = FS_LINK;
                        end
                    end
                end
            end
            FS_LINK: begin
                if (q.pend) begin
                    d.cs_n = 1'b1;
                    d.held = 1'b0;
                    d.st   = FS_TAIL;
                end else if (accept) begin
                    d.sh     = in_byte;
                    d.is_cmd = in_is_cmd;
                    d.last   = in_last;
                    if (in_is_cmd) begin
                        d.cs_n = 1'b1;
                        d.held = 1'b1;
                        d.st   = FS_TAIL;
                    end else begin
                        d.half = 4'h0;
                        d.st   = FS_SHIFT;
                    end
                end
            end
            FS_TAIL: begin
                if (tick) begin
                    d.dc = 1'b1;
                    d.st = FS_GAP;
                end
            end
            FS_GAP: begin
                if (tick) begin
                    if (q.held) begin
                        d.held = 1'b0;
                        d.dc   = !q.is_cmd;
                        d.st   = FS_SETUP;
                    end else begin
                        d.st = FS_IDLE;
                    end
                end
            end
            FS_RESET: begin
                if (seq_done) d.st = FS_IDLE;
            end
            default: d = FR_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= FR_RST;
        else        q <= d;
    end

    assign sclk = q.sclk;
    assign mosi = q.sh[7];
    assign cs_n = q.cs_n;
    assign dc   = q.dc;

    // R2: the serial clock only runs inside a frame
    a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> !q.cs_n);

    // R4: command/data select is frozen while chip select is low
    a_r4_dc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.cs_n && !$past(q.cs_n)) |-> $stable(q.dc));

    // R10: nothing is accepted while the serial clock is high
    a_r10_busy_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        q.sclk |-> !in_ready);

    // R9: the reset sequence only starts with chip select released
    a_r9_reset_outside_frame: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> q.cs_n);

    // R6: a data byte taken into an open burst keeps chip select low
    a_r6_burst_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == FS_LINK) && accept && !in_is_cmd) |=> !q.cs_n);

endmodule

// File: rtl/epd_spi_framer.sv
`timescale 1ns/1ps
module epd_spi_framer #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int SCK_DIV     = 2,
    parameter int RST_PRE_MS  = 20,
    parameter int RST_LOW_MS  = 2,
    parameter int RST_POST_MS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_cmd,
    input  logic       in_last,
    input  logic       rst_req,
    output logic       rst_done,
    output logic       panel_sclk,
    output logic       panel_mosi,
    output logic       panel_cs_n,
    output logic       panel_dc,
    output logic       panel_rst_n
);
    logic tick, div_en, seq_start, seq_done;

    epd_sck_div #(.SCK_DIV(SCK_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (div_en),
        .tick  (tick)
    );

    epd_rst_seq #(
        .CLK_HZ      (CLK_HZ),
        .RST_PRE_MS  (RST_PRE_MS),
        .RST_LOW_MS  (RST_LOW_MS),
        .RST_POST_MS (RST_POST_MS)
    ) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (seq_start),
        .line_n (panel_rst_n),
        .done   (seq_done)
    );

    epd_spi_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_byte   (in_byte),
        .in_is_cmd (in_is_cmd),
        .in_last   (in_last),
        .rst_req   (rst_req),
        .tick      (tick),
        .div_en    (div_en),
        .seq_start (seq_start),
        .seq_done  (seq_done),
        .sclk      (panel_sclk),
        .mosi      (panel_mosi),
        .cs_n      (panel_cs_n),
        .dc        (panel_dc)
    );

    assign rst_done = seq_done;

endmodule

// File: tb/epd_spi_framer_bench.sv
`timescale 1ns/1ps
module epd_spi_framer_bench;
    localparam int CLK_HZ  = 4000;
    localparam int SCK_DIV = 3;
    localparam int MS      = CLK_HZ / 1000;
    localparam int PRE     = 20 * MS;
    localparam int LOW     = 2 * MS;
    localparam int POST    = 20 * MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic in_is_cmd = 1'b0;
    logic in_last = 1'b0;
    logic rst_req = 1'b0;
    logic in_ready, rst_done, panel_sclk, panel_mosi, panel_cs_n, panel_dc, panel_rst_n;

    always #10 clk = ~clk;

    epd_spi_framer #(.CLK_HZ(CLK_HZ), .SCK_DIV(SCK_DIV)) u_epd_spi_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_cmd(in_is_cmd), .in_last(in_last),
        .rst_req(rst_req), .rst_done(rst_done), .panel_sclk(panel_sclk),
        .panel_mosi(panel_mosi), .panel_cs_n(panel_cs_n), .panel_dc(panel_dc),
        .panel_rst_n(panel_rst_n)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference model: expected bytes, select values, frame numbers
    int    exp_b[$];
    int    exp_dc[$];
    int    exp_f[$];
    string exp_tag[$];
    int    exp_frame = 0;
    bit    burst_open = 1'b0;

    task automatic send(input logic [7:0] b, input bit cmd, input bit last, input string tag);
        if (cmd || !burst_open) exp_frame++;
        burst_open = !cmd && !last;
        exp_b.push_back(int'(b));
        exp_dc.push_back(cmd ? 0 : 1);
        exp_f.push_back(exp_frame);
        exp_tag.push_back(tag);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_is_cmd = cmd; in_last = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #2;
        in_valid = 1'b0;
    endtask

    task automatic pulse_reset();
        burst_open = 1'b0;
        @(posedge clk); #2 rst_req = 1'b1;
        @(posedge clk); #2 rst_req = 1'b0;
    endtask

    // per-clock protocol monitor
    bit   p_sclk = 0, p_cs = 1, p_dc = 1, p_mosi = 0, p_rst = 1;
    int   got_frame = 0, bits = 0, hi_cnt = 0, gap_cnt = 1000;
    int   pre_cnt = 0, low_cnt = 0, post_cnt = 0;
    bit   pre_arm = 0, post_arm = 0;
    logic [7:0] sr = 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (panel_sclk && in_ready) chk(0, "R10 ready while sclk high", 1, 0);
            if (!panel_rst_n && in_ready) chk(0, "R10 ready during reset", 1, 0);
            if (!panel_rst_n && !panel_cs_n) chk(0, "R9 reset low inside frame", 0, 1);
            if (!panel_cs_n && !p_cs && panel_dc != p_dc) chk(0, "R4 dc moved in frame", panel_dc, p_dc);
            if (!panel_cs_n && panel_sclk && panel_mosi != p_mosi) chk(0, "R2 mosi moved while sclk high", panel_mosi, p_mosi);
            if (panel_cs_n && panel_sclk) chk(0, "R2 sclk outside frame", 1, 0);
            if (p_cs && !panel_cs_n) begin
                chk(panel_dc == p_dc, "R4 dc settled before cs fall", panel_dc, p_dc);
                chk(gap_cnt >= SCK_DIV, "R11 cs high gap", gap_cnt, SCK_DIV);
                got_frame++;
                bits = 0;
            end
            if (!p_cs && panel_cs_n) begin
                chk(bits == 0, "R6 cs rose on byte boundary", bits, 0);
                chk(panel_dc == p_dc, "R4 cs rises before dc", panel_dc, p_dc);
                gap_cnt = 1;
            end else if (panel_cs_n) gap_cnt++;
            if (!p_sclk && panel_sclk) begin
                hi_cnt = 1;
                sr = {sr[6:0], panel_mosi};
                bits++;
                if (bits == 8) begin
                    bits = 0;
                    if (exp_b.size() == 0) chk(0, "R2 unexpected byte", int'(sr), -1);
                    else begin
                        automatic int    eb = exp_b.pop_front();
                        automatic int    ed = exp_dc.pop_front();
                        automatic int    ef = exp_f.pop_front();
                        automatic string et = exp_tag.pop_front();
                        chk(int'(sr) == eb, "R2 byte value MSB first", int'(sr), eb);
                        chk(int'(panel_dc) == ed, "R4 dc value", int'(panel_dc), ed);
                        chk(got_frame == ef, {et, " frame grouping"}, got_frame, ef);
                    end
                end
            end else if (panel_sclk) hi_cnt++;
            if (p_sclk && !panel_sclk) chk(hi_cnt == SCK_DIV, "R3 sclk high length", hi_cnt, SCK_DIV);
            // reset sequence timing
            if (rst_req) begin pre_arm = 1; pre_cnt = 0; end
            else if (pre_arm && panel_rst_n) pre_cnt++;
            if (p_rst && !panel_rst_n) begin
                chk(pre_arm && pre_cnt >= PRE, "R8 leading high length", pre_cnt, PRE);
                chk(panel_cs_n == 1'b1, "R9 cs high at reset", panel_cs_n, 1);
                pre_arm = 0; low_cnt = 1;
            end else if (!panel_rst_n) low_cnt++;
            if (!p_rst && panel_rst_n) begin
                chk(low_cnt == LOW, "R8 low length", low_cnt, LOW);
                post_arm = 1; post_cnt = 1;
            end else if (post_arm) begin
                if (rst_done) begin
                    chk(post_cnt == POST, "R8 trailing high length", post_cnt, POST);
                    post_arm = 0;
                end else post_cnt++;
            end
            p_sclk = panel_sclk; p_cs = panel_cs_n; p_dc = panel_dc;
            p_mosi = panel_mosi; p_rst = panel_rst_n;
        end
    end

    task automatic wait_reset_done();
        while (!rst_done) @(negedge clk);
        @(negedge clk);
        chk(rst_done == 1'b0, "R8 done is one cycle", rst_done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(panel_cs_n == 1, "R1 cs idle", panel_cs_n, 1);
        chk(panel_dc == 1, "R1 dc idle", panel_dc, 1);
        chk(panel_sclk == 0, "R1 sclk idle", panel_sclk, 0);
        chk(panel_rst_n == 1, "R1 reset line idle", panel_rst_n, 1);
        chk(in_ready == 1, "R1 ready idle", in_ready, 1);

        // R8: full reset sequence
        pulse_reset();
        while (panel_rst_n) @(negedge clk);
        chk(in_ready == 0, "R10 ready low in reset", in_ready, 0);
        wait_reset_done();

        // R4: lone command
        send(8'hA5, 1'b1, 1'b1, "R4");
        @(negedge clk);
        chk(in_ready == 0, "R10 ready low while shifting", in_ready, 0);
        // R5: lone data byte
        send(8'h3C, 1'b0, 1'b1, "R5");
        // R6: command then three-byte burst
        send(8'h24, 1'b1, 1'b0, "R7");
        send(8'h01, 1'b0, 1'b0, "R6");
        send(8'h80, 1'b0, 1'b0, "R6");
        send(8'hFF, 1'b0, 1'b1, "R6");
        // R7: burst cut short by a command
        send(8'h55, 1'b0, 1'b0, "R7");
        send(8'h22, 1'b1, 1'b0, "R7");
        send(8'hC7, 1'b0, 1'b1, "R7");
        // R9: reset requested mid-byte inside an open burst
        send(8'h96, 1'b0, 1'b0, "R9");
        pulse_reset();
        wait_reset_done();
        // R11: back-to-back commands
        send(8'h12, 1'b1, 1'b1, "R11");
        send(8'h0F, 1'b1, 1'b1, "R11");
        repeat (120) @(negedge clk);
        chk(exp_b.size() == 0, "R2 all bytes delivered", exp_b.size(), 0);
        chk(panel_cs_n == 1 && panel_dc == 1, "R4 lines idle at end", {panel_cs_n, panel_dc}, 3);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule